// File: doc/BRIEF.md
# Bus wake-up pattern detector

This block listens to a sampled single-bit bus level while its host transceiver is in its low-power mode. It looks for a deliberate remote wake-up request: a sufficiently long dominant period, then a sufficiently long recessive period, then dominant again, with all three finished inside a bounded window. The window means that a bus stuck dominant, for example by a short, can never count as a wake-up. The required pattern is dominant, recessive, dominant. A stuck bus supplies only the first part of it.

Once the pattern is seen, the block raises a wake-up flag and starts copying the bus onto the receive output, one cycle late and inverted: dominant gives low and recessive gives high. This lets the host controller see the bus traffic. Until then the receive output stays high. The mode controller drives the enable input. Dropping enable, as happens on entry to full-power mode, clears the report and restarts the search.

All durations are counted in clock cycles and set by parameters. The first filter length `FLT1_CYC` and the second filter length `FLT2_CYC` must each be at least 2. The timeout `TMO_CYC` must exceed `FLT1_CYC + 2*FLT2_CYC`.

Top module: `wkp_detect`

## Requirements
- R1: After reset, `wake_o` is 0 and `rxd_o` is 1.
- R2: A search starts on the first dominant sample (`bus_dom_i`=1) taken while idle and enabled. That sample is pattern index 1. If fewer than `FLT1_CYC` consecutive dominant samples come before the first recessive sample, the search returns to idle with no wake-up.
- R3: After a valid first dominant run, fewer than `FLT2_CYC` consecutive recessive samples before the next dominant sample abort the search with no wake-up.
- R4: After a valid recessive run, `FLT2_CYC` consecutive dominant samples complete the pattern. `wake_o` is 1 from the clock edge that takes the completing sample.
- R5: The completing sample must have pattern index at most `TMO_CYC`. An index of exactly `TMO_CYC` still wakes. Reaching index `TMO_CYC`+1 abandons the search with no wake-up.
- R6: While `wake_o` is 0, `rxd_o` is 1 on the following cycle.
- R7: While `wake_o` is 1 and enable is high, `rxd_o` on the next cycle equals the inverse of the sampled `bus_dom_i`.
- R8: When `en_i` is 0, the next cycle shows `wake_o`=0 and `rxd_o`=1, and bus activity has no effect.
- R9: A bus held dominant for any length of time never sets `wake_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Low-power mode active; low clears the detector |
| bus_dom_i | input | 1 | Sampled bus level, 1 = dominant |
| rxd_o | output | 1 | Receive level: high at rest, inverse of the bus after wake-up |
| wake_o | output | 1 | Wake-up pattern detected |

## Verification
Completion of the third event and expiry of the timeout can both occur on the same edge. The bench provokes this by sweeping run lengths so that the completing sample lands at index `TMO_CYC` (must wake) and at index `TMO_CYC`+1 (must not). The bench predicts the result from the arithmetic of the run lengths alone. Short runs at each stage, repeated glitches and a bus held dominant are swept alongside these cases.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_DOM1,
    WK_REC,
    WK_DOM2,
    WK_WOKE
  } wk_state_e;

  // count one more sample, holding at the cap
  function automatic int unsigned inc_sat(int unsigned v, int unsigned cap);
    return (v < cap) ? v + 1 : cap;
  endfunction

  // has a run of v samples met the filter length lim
  function automatic logic reached(int unsigned v, int unsigned lim);
    return v >= lim;
  endfunction

endpackage

// File: rtl/wkp_window.sv
module wkp_window #(
  parameter int unsigned TMO_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  output logic expired_o
);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] tmr_q;

  assign expired_o = (tmr_q == TW'(TMO_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tmr_q <= '0;
    else if (start_i)                tmr_q <= TW'(1);
    else if (!active_i)              tmr_q <= '0;
    else if (!expired_o)             tmr_q <= tmr_q + TW'(1);
  end

  p_window_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= TW'(TMO_CYC));
  p_start_loads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> tmr_q == TW'(1));

endmodule

// File: rtl/wkp_seq.sv
module wkp_seq
  import wkp_pkg::*;
#(
  parameter int unsigned FLT1_CYC = 200,
  parameter int unsigned FLT2_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bus_dom_i,
  input  logic expired_i,
  output logic start_o,
  output logic active_o,
  output logic woke_o
);
  localparam int unsigned CMAX = (FLT1_CYC > FLT2_CYC) ? FLT1_CYC : FLT2_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  wk_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc  = CW'(inc_sat(32'(cnt_q), CMAX));
  assign active_o = (st_q == WK_DOM1) || (st_q == WK_REC) || (st_q == WK_DOM2);
  assign woke_o   = (st_q == WK_WOKE);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    if (!en_i) begin
      st_d  = WK_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        WK_IDLE: if (bus_dom_i) begin
          st_d    = WK_DOM1;
          cnt_d   = CW'(1);
          start_o = 1'b1;
        end
        WK_DOM1: begin
          if (expired_i)                    st_d = WK_IDLE;
          else if (bus_dom_i)               cnt_d = cnt_inc;
          else if (reached(32'(cnt_q), FLT1_CYC)) begin
            st_d  = WK_REC;
            cnt_d = CW'(1);
          end else                          st_d = WK_IDLE;
        end
        WK_REC: begin
          if (expired_i)                    st_d = WK_IDLE;
          else if (!bus_dom_i)              cnt_d = cnt_inc;
          else if (reached(32'(cnt_q), FLT2_CYC)) begin
            st_d  = WK_DOM2;
            cnt_d = CW'(1);
          end else                          st_d = WK_IDLE;
        end
        WK_DOM2: begin
          if (expired_i || !bus_dom_i)      st_d = WK_IDLE;
          else if (reached(32'(cnt_inc), FLT2_CYC)) st_d = WK_WOKE;
          else                              cnt_d = cnt_inc;
        end
        WK_WOKE: st_d = WK_WOKE;
        default: st_d = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  p_idle_not_woke_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WK_IDLE) |=> (st_q != WK_WOKE));
  p_wake_on_dom_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WK_DOM2) ##1 (st_q == WK_WOKE) |-> $past(bus_dom_i));
  p_expiry_aborts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_i && active_o) |=> (st_q == WK_IDLE));

endmodule

// File: rtl/wkp_detect.sv
module wkp_detect #(
  parameter int unsigned FLT1_CYC = 200,
  parameter int unsigned FLT2_CYC = 40,
  parameter int unsigned TMO_CYC  = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bus_dom_i,
  output logic rxd_o,
  output logic wake_o
);
  logic start_w, active_w, expired_w, woke_w;
  logic rxd_q;

  wkp_seq #(.FLT1_CYC(FLT1_CYC), .FLT2_CYC(FLT2_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .bus_dom_i (bus_dom_i),
    .expired_i (expired_w),
    .start_o   (start_w),
    .active_o  (active_w),
    .woke_o    (woke_w)
  );

  wkp_window #(.TMO_CYC(TMO_CYC)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .active_i  (active_w),
    .expired_o (expired_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_q <= 1'b1;
    else         rxd_q <= !(woke_w && en_i && bus_dom_i);
  end

  assign rxd_o  = rxd_q;
  assign wake_o = woke_w;

  p_rxd_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_o |=> rxd_o);
  p_mirror_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && en_i) |=> (rxd_o == !$past(bus_dom_i)));
  p_disable_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!wake_o && rxd_o));
  p_rise_on_dom_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(bus_dom_i));

endmodule

// File: tb/wkp_detect_tb.sv
module wkp_detect_tb;
  localparam int F1 = 6;
  localparam int F2 = 3;
  localparam int TM = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic bus = 1'b0;
  logic rxd, wake;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wkp_detect #(.FLT1_CYC(F1), .FLT2_CYC(F2), .TMO_CYC(TM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bus_dom_i(bus),
    .rxd_o(rxd), .wake_o(wake)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  // hold a bus level for n sampling edges; returns at a falling edge
  task automatic drive(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      bus = lvl;
      @(negedge clk);
    end
  endtask

  task automatic restart();
    en = 1'b0;
    drive(1'b0, 2);
    check(wake, 1'b0, "R8", "wake after disable");
    check(rxd, 1'b1, "R8", "rxd after disable");
    en = 1'b1;
    drive(1'b0, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d1s[3] = '{F1 - 1, F1, F1 + 2};
    int rs[3]  = '{F2 - 1, F2, F2 + 1};
    int d2s[3] = '{F2 - 1, F2, F2 + 4};
    @(negedge clk);
    check(wake, 1'b0, "R1", "wake in reset");
    check(rxd, 1'b1, "R1", "rxd in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // sweep of run lengths; completion index d1+r+F2 straddles TM
    foreach (d1s[a]) foreach (rs[b]) foreach (d2s[c]) begin
      int d1 = d1s[a];
      int r  = rs[b];
      int d2 = d2s[c];
      logic exp;
      string tag;
      exp = (d1 >= F1) && (r >= F2) && (d2 >= F2) && (d1 + r + F2 <= TM);
      if (d1 < F1)              tag = "R2";
      else if (r < F2)          tag = "R3";
      else if (d2 < F2)         tag = "R4";
      else if (d1 + r + F2 > TM) tag = "R5";
      else                      tag = "R4";
      restart();
      drive(1'b1, d1);
      drive(1'b0, r);
      drive(1'b1, d2);
      drive(1'b0, TM + 4);
      check(wake, exp, tag, $sformatf("wake d1=%0d r=%0d d2=%0d", d1, r, d2));
      check(rxd, 1'b1, "R6", "rxd high while bus recessive");
      if (exp) begin
        drive(1'b1, 1);
        check(rxd, 1'b0, "R7", "rxd low on dominant");
        drive(1'b1, 1);
        check(wake, 1'b1, "R7", "wake held");
        drive(1'b0, 1);
        check(rxd, 1'b1, "R7", "rxd high on recessive");
        bus = 1'b1;
        en = 1'b0;
        @(negedge clk);
        check(rxd, 1'b1, "R8", "rxd high when disabled on dominant");
        check(wake, 1'b0, "R8", "wake cleared by disable");
      end else begin
        drive(1'b1, 1);
        check(rxd, 1'b1, "R6", "rxd stays high without wake");
      end
    end

    // repeated single-sample glitches
    restart();
    for (int k = 0; k < 30; k++) begin
      drive(1'b1, 1);
      drive(1'b0, 1);
      check(rxd, 1'b1, "R6", "rxd during glitches");
    end
    drive(1'b0, TM + 4);
    check(wake, 1'b0, "R2", "glitch train");

    // bus stuck dominant
    restart();
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, 10);
      check(wake, 1'b0, "R9", "stuck dominant wake");
      check(rxd, 1'b1, "R9", "stuck dominant rxd");
    end

    // valid pattern while disabled has no effect
    en = 1'b0;
    drive(1'b0, 3);
    drive(1'b1, F1);
    drive(1'b0, F2);
    drive(1'b1, F2 + 2);
    check(wake, 1'b0, "R8", "pattern while disabled");
    check(rxd, 1'b1, "R8", "rxd while disabled");
    en = 1'b1;
    drive(1'b0, TM + 4);
    check(wake, 1'b0, "R8", "no late wake after enable");

    // exact boundary: completion at index TM
    restart();
    drive(1'b1, TM - 2 * F2);
    drive(1'b0, F2);
    drive(1'b1, F2);
    check(wake, 1'b1, "R5", "completion at timeout limit");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule